// File: doc/BRIEF.md
# Pulse-Count Temperature Digitizer

This block turns the pulse train of a relaxation-oscillator temperature sensor into a signed temperature in degrees Celsius. The sensor's capacitor charges at a rate that depends on temperature. A comparator discharges it each time it crosses a reference, and each crossing produces a short pulse. The block counts the rising edges of that pulse over a conversion window of fixed length. At the end of each window it turns the count into a temperature, stores it, and raises a one-clock strobe.

The counter is only eight bits wide. The expected totals per window lie between 295 and 455, so the count always wraps exactly once. This means the wrapped value can be read directly. Subtracting a fixed offset of 79 gives the temperature, with one pulse per degree. A wrapped count outside the expected band raises an out-of-range flag alongside the result.

The comparator input is asynchronous to the block clock, so it passes through a synchronizer before edge detection. The window timer starts again on every reset, which means a window cut short by reset never produces a result.

Top module: `tempdig_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, `valid_o`, `oor_o` and `temp_o` are all 0.
- R2: A window lasts `WINDOW_CYCLES` clocks, counted from the first rising clock edge after reset falls. `valid_o` is high for exactly one clock after the last edge of each window and low at every other time.
- R3: Each rising edge of `comp_i`, taken after a two-flop synchronizer, adds exactly one to the count. A pulse held high for several clocks therefore counts once.
- R4: The count is 8 bits wide and wraps modulo 256. It starts again from zero in every window, so a result depends only on the edges inside its own window.
- R5: `temp_o` is the wrapped count minus 79, as an 8-bit two's-complement value. A wrapped count of 39 gives -40, 199 gives 120, and 79 gives 0.
- R6: `oor_o` is updated together with `temp_o`. It is 1 exactly when the wrapped count is below 39 or above 199.
- R7: `temp_o` and `oor_o` hold their values between strobes.
- R8: If reset is asserted in the middle of a window, the pulses counted so far are discarded. No strobe occurs until a complete window has run after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high; restarts the window |
| comp_i | input | 1 | Comparator discharge pulse, asynchronous |
| temp_o | output | 8 | Signed temperature in degrees Celsius, held between strobes |
| oor_o | output | 1 | Last result lay outside the expected count band |
| valid_o | output | 1 | One-clock strobe when a new result is stored |

## Verification
Some faults sit in internal state and only reach the ports at the next window boundary, up to `WINDOW_CYCLES` clocks later. These include a miscounted edge, a counter that is not cleared between windows, and a window timer that is off by one. Each one shows up as a `temp_o` that differs from the pulse count by a fixed amount, or as a strobe that arrives in the wrong cycle. Synchronizer and edge-detector faults show up in the same window as a count that is too high for pulses lasting several clocks. Faults in the hold path show up in the middle of the following window, as a `temp_o` that changes without a strobe.

// File: rtl/tempdig_pkg.sv
package tempdig_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0]        count_t;
    typedef logic signed [CNT_W-1:0] temp_t;

    typedef struct packed {
        temp_t temp;
        logic  oor;
    } result_t;

    // Convert a wrapped count into a temperature and a band check
    function automatic result_t to_result(input count_t c, input count_t off,
                                          input count_t lo, input count_t hi);
        result_t r;
        r.temp = temp_t'(c - off);
        r.oor  = (c < lo) || (c > hi);
        return r;
    endfunction

endpackage

// File: rtl/tempdig_edge.sv
module tempdig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;

    // R3
    rise_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tempdig_timer.sv
module tempdig_timer #(
    parameter int WINDOW_CYCLES = 5906
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic win_end_o
);
    localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                tick_q <= '0;
        else if (tick_q == LAST)  tick_q <= '0;
        else                      tick_q <= tick_q + 1'b1;
    end

    assign win_end_o = (tick_q == LAST);

    // R2
    tick_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q <= LAST);

endmodule

// File: rtl/tempdig_counter.sv
module tempdig_counter
    import tempdig_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   rise_i,
    input  logic   win_end_i,
    output count_t total_o
);
    count_t cnt_q;

    assign total_o = cnt_q + count_t'(rise_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)          cnt_q <= '0;
        else if (win_end_i) cnt_q <= '0;
        else                cnt_q <= total_o;
    end

    // R4
    cnt_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        win_end_i |=> cnt_q == '0);

    // R3
    cnt_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!win_end_i && !rise_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tempdig_result.sv
module tempdig_result
    import tempdig_pkg::*;
#(
    parameter int OFFSET = 79,
    parameter int LO     = 39,
    parameter int HI     = 199
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    win_end_i,
    input  count_t  total_i,
    output result_t res_o,
    output logic    valid_o
);
    result_t res_q;
    logic    valid_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= win_end_i;
            if (win_end_i)
                res_q <= to_result(total_i, count_t'(OFFSET), count_t'(LO), count_t'(HI));
        end
    end

    assign res_o   = res_q;
    assign valid_o = valid_q;

    // R2
    strobe_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_q |=> !valid_q);

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !win_end_i |=> $stable(res_q));

    // R6
    band_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_q && !res_q.oor) |-> (res_q.temp >= temp_t'(LO - OFFSET) &&
                                     res_q.temp <= temp_t'(HI - OFFSET)));

endmodule

// File: rtl/tempdig_top.sv
module tempdig_top
    import tempdig_pkg::*;
#(
    parameter int WINDOW_CYCLES = 5906,
    parameter int SYNC_STAGES   = 2,
    parameter int OFFSET        = 79,
    parameter int LO            = 39,
    parameter int HI            = 199
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              comp_i,
    output logic signed [7:0] temp_o,
    output logic              oor_o,
    output logic              valid_o
);
    logic    rise;
    logic    win_end;
    count_t  total;
    result_t res;

    tempdig_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk_i(clk_i), .rst_i(rst_i), .async_i(comp_i), .rise_o(rise));

    tempdig_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) timer_i (
        .clk_i(clk_i), .rst_i(rst_i), .win_end_o(win_end));

    tempdig_counter counter_i (
        .clk_i(clk_i), .rst_i(rst_i), .rise_i(rise),
        .win_end_i(win_end), .total_o(total));

    tempdig_result #(.OFFSET(OFFSET), .LO(LO), .HI(HI)) result_i (
        .clk_i(clk_i), .rst_i(rst_i), .win_end_i(win_end),
        .total_i(total), .res_o(res), .valid_o(valid_o));

    assign temp_o = res.temp;
    assign oor_o  = res.oor;

    // R8
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> !valid_o);

endmodule

// File: tb/tempdig_top_tb.sv
module tempdig_top_tb_top;
    localparam int W = 1000;
    localparam int NV = 7;
    localparam int VEC [NV] = '{295, 455, 375, 335, 294, 456, 260};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              comp = 1'b0;
    logic signed [7:0] temp_o;
    logic              oor_o;
    logic              valid_o;

    int total_checks = 0;
    int failed = 0;
    bit done = 1'b0;
    int prev_temp = 0;
    int prev_oor = 0;

    always #10 clk = ~clk;

    tempdig_top #(.WINDOW_CYCLES(W)) dut_i (
        .clk_i(clk), .rst_i(rst), .comp_i(comp),
        .temp_o(temp_o), .oor_o(oor_o), .valid_o(valid_o));

    task automatic chk(input string req, input int act, input int exp);
        total_checks++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one full window of n pulses, each w clocks high and w low.
    task automatic run_window(input int n, input int w, input string tag);
        bit early = 1'b0;
        bit moved = 1'b0;
        for (int j = 0; j < W; j++) begin
            comp = (j >= 10 && j < 10 + 2*w*n && ((j - 10) % (2*w)) < w);
            @(negedge clk);
            if (j < W - 1 && valid_o) early = 1'b1;
            if (j == W/2 && ($signed(temp_o) != prev_temp || oor_o != prev_oor[0]))
                moved = 1'b1;
        end
        comp = 1'b0;
        chk({"R2 no early strobe ", tag}, early, 0);
        chk({"R7 hold mid-window ", tag}, moved, 0);
        chk({"R2 strobe at window end ", tag}, valid_o, 1);
    endtask

    task automatic expect_result(input int n, input string req);
        int wr = n % 256;
        logic signed [7:0] et = 8'(wr - 79);
        int eo = (wr < 39 || wr > 199) ? 1 : 0;
        chk({req, " temp"}, $signed(temp_o), et);
        chk({"R6 oor ", req}, oor_o, eo);
        prev_temp = et;
        prev_oor = eo;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", valid_o, 0);
        chk("R1 temp in reset", $signed(temp_o), 0);
        chk("R1 oor in reset", oor_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after release", valid_o, 0);
        // Back up one cycle: restart from reset so window alignment is known
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // R4 R5 R6 table walk
        for (int v = 0; v < NV; v++) begin
            run_window(VEC[v], 1, "table");
            expect_result(VEC[v], "R5 R4 table");
        end
        @(negedge clk);
        chk("R2 strobe one clock", valid_o, 0);
        // Realign: that extra negedge consumed a cycle of the next window
        rst = 1'b1;
        @(negedge clk);
        chk("R1 temp cleared", $signed(temp_o), 0);
        rst = 1'b0;
        prev_temp = 0;
        prev_oor = 0;

        // R3 wide pulses count once
        run_window(150, 3, "wide");
        expect_result(150, "R3 wide pulses");

        // R5 boundary: exactly 79 wrapped -> 0
        run_window(335, 1, "zero");
        expect_result(335, "R5 zero point");

        // R8 reset mid-window discards partial count
        for (int j = 0; j < 400; j++) begin
            comp = (j >= 10 && j < 310 && ((j - 10) % 2) == 0);
            @(negedge clk);
        end
        comp = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 no strobe in reset", valid_o, 0);
        rst = 1'b0;
        prev_temp = 0;
        prev_oor = 0;
        run_window(320, 1, "after reset");
        expect_result(320, "R8 fresh window");

        done = 1'b1;
        $display("%0d/%0d checks passed", total_checks - failed, total_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total_checks++;
            failed++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total_checks - failed, total_checks);
            $finish;
        end
    end

endmodule